// File: doc/BRIEF.md
# Weighted Round-Robin Grant Arbiter

The block shares one resource among four clients. Each clock it forms an effective request vector: a mode bit chooses either the external or the internal request inputs, and a per-client enable mask then removes clients. A state machine picks one owner from that vector. The machine has an idle state and one owner state per client. It changes owner only on slow arbitration ticks. A divider makes one tick every N system clocks, where N is programmable.

Each client has an 8-bit weight. The weight sets how many ticks the client keeps ownership once it wins. When that hold time runs out, ownership passes to the next requesting client in circular order after the current owner. Leaving idle uses a fixed priority instead, with client 0 first. Three conditions force the machine back to idle at the next clock edge without waiting for a tick:
- reset is asserted;
- the enable input is low;
- the effective request vector is empty.

A small write-only register port loads the four weights, the tick period, the source mode and the mask.

Top module: `wrr_arb_top`

## Requirements
- R1: `grant` never has more than one bit set. It is 0 while `rst_n` is low and right after reset. Bit k of `grant` means client k owns the resource.
- R2: From idle, on a tick cycle, ownership goes to the lowest-numbered client in the effective request vector (bit 0 has the highest priority). `grant` shows the new owner after that clock edge.
- R3: When the current owner's hold time has run out, the next tick searches circularly from the owner's index plus one, wrapping past 3 to 0. The first requesting client found becomes the owner. The current owner is considered last.
- R4: On every change of owner, and on every re-grant to the same client, a hold counter loads the new owner's weight, with a weight of 0 used as 1. Each tick while ownership is held decrements the counter. An owner with weight W keeps `grant` for exactly W ticks.
- R5: A tick occurs when a free-running clock counter reaches P-1, and the counter then restarts at 0. P is the period register, and P=0 behaves as P=1. The counter is held at 0 while `arb_en` is low. After reset, or after `arb_en` rises, the first tick comes on the P-th clock.
- R6: If `arb_en` is low, or the effective request vector is all zero, `grant` is 0 after the next clock edge, whether or not a tick occurs.
- R7: The effective request for client k is the mask bit k AND the request for client k. The request comes from `ext_req` when mode bit 0 is 0, and from `int_req` when mode bit 0 is 1.
- R8: Register writes take effect at the clock edge where `cfg_we` is high. The addresses are:
  - 0 to 3: weight of clients 0 to 3;
  - 4: tick period;
  - 5: mode (bit 0);
  - 6: mask (bits 3:0).

  Other addresses are ignored. The reset values are all weights 1, period 5, mode 0 and mask 4'b1111.
- R9: While `arb_en` is high and the effective request vector is non-zero, `grant` changes only at the edge that ends a tick cycle.
- R10: While the hold counter has not expired, ownership is kept even if the owner's own request drops, provided some effective request remains.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arb_en | input | 1 | Arbitration enable |
| ext_req | input | 4 | External request vector, bit k for client k |
| int_req | input | 4 | Internal request vector, bit k for client k |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| grant | output | 4 | One-hot owner vector, 0 when idle |

## Verification
An error in the owner index, the hold counter or the tick counter shows up at `grant`. It appears at the first tick edge where the wrong value affects a decision. For the hold counter or tick counter this can be up to the weight times the period in clocks after the fault. A wrong idle or drop decision is visible one clock after the triggering input. The bench runs a model of the requirements every cycle and compares `grant` at each falling edge. It sweeps all request patterns from idle, periods of 0 to 7 and weights of 0 to 4, and it toggles enable and the request source, so each of these faults is caught within one hold window.

// File: rtl/wrr_arb_pkg.sv
package wrr_arb_pkg;
   typedef enum logic {
      SRC_EXT = 1'b0,
      SRC_INT = 1'b1
   } src_sel_e;

   localparam int unsigned WRR_RST_PERIOD = 5;
   localparam int unsigned WRR_RST_WEIGHT = 1;
endpackage

// File: rtl/wrr_cfg_regs.sv
module wrr_cfg_regs
   import wrr_arb_pkg::*;
#(
   parameter int unsigned N_CLI  = 4,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         we,
   input  logic [ADDR_W-1:0]            addr,
   input  logic [DATA_W-1:0]            wdata,
   output logic [N_CLI-1:0][DATA_W-1:0] weights,
   output logic [DATA_W-1:0]            period,
   output src_sel_e                     mode,
   output logic [N_CLI-1:0]             filt
);
   localparam logic [ADDR_W-1:0] PER_ADDR  = ADDR_W'(N_CLI);
   localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(N_CLI + 1);
   localparam logic [ADDR_W-1:0] FILT_ADDR = ADDR_W'(N_CLI + 2);

   for (genvar i = 0; i < N_CLI; i++) begin : g_wgt
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            weights[i] <= DATA_W'(WRR_RST_WEIGHT);
         else if (we && addr == ADDR_W'(i))
            weights[i] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period <= DATA_W'(WRR_RST_PERIOD);
         mode   <= SRC_EXT;
         filt   <= '1;
      end else if (we) begin
         if (addr == PER_ADDR)
            period <= wdata;
         if (addr == MODE_ADDR)
            mode <= src_sel_e'(wdata[0]);
         if (addr == FILT_ADDR)
            filt <= wdata[N_CLI-1:0];
      end
   end
endmodule

// File: rtl/wrr_req_select.sv
module wrr_req_select
   import wrr_arb_pkg::*;
#(
   parameter int unsigned N_CLI = 4
) (
   input  logic [N_CLI-1:0] ext_req,
   input  logic [N_CLI-1:0] int_req,
   input  src_sel_e         mode,
   input  logic [N_CLI-1:0] filt,
   output logic [N_CLI-1:0] req_eff
);
   for (genvar i = 0; i < N_CLI; i++) begin : g_sel
      assign req_eff[i] = filt[i] & ((mode == SRC_INT) ? int_req[i] : ext_req[i]);
   end
endmodule

// File: rtl/wrr_tick_gen.sv
module wrr_tick_gen #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [DATA_W-1:0] period,
   output logic              tick
);
   logic [DATA_W-1:0] cnt_q;
   logic [DATA_W-1:0] last;

   assign last = (period == '0) ? '0 : period - 1'b1;
   assign tick = en && (cnt_q >= last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!en || tick)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/wrr_fsm.sv
module wrr_fsm #(
   parameter int unsigned N_CLI  = 4,
   parameter int unsigned DATA_W = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         en,
   input  logic                         tick,
   input  logic [N_CLI-1:0]             req,
   input  logic [N_CLI-1:0][DATA_W-1:0] weights,
   output logic [N_CLI-1:0]             grant
);
   localparam int unsigned IDX_W = (N_CLI > 1) ? $clog2(N_CLI) : 1;
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_CLI - 1);

   logic              busy_q, busy_d;
   logic [IDX_W-1:0]  idx_q, idx_d;
   logic [DATA_W-1:0] hold_q, hold_d;
   logic [IDX_W-1:0]  rot_start;
   logic [IDX_W-1:0]  pick_idle, pick_rot;

   function automatic logic [IDX_W-1:0] first_req(input logic [N_CLI-1:0] r,
                                                   input logic [IDX_W-1:0] start);
      logic [IDX_W-1:0] res;
      res = start;
      for (int off = N_CLI - 1; off >= 0; off--) begin
         int j;
         j = (int'(start) + off) % N_CLI;
         if (r[j])
            res = IDX_W'(j);
      end
      return res;
   endfunction

   function automatic logic [DATA_W-1:0] load_of(input logic [N_CLI-1:0][DATA_W-1:0] w,
                                                  input logic [IDX_W-1:0] k);
      return (w[k] == '0) ? DATA_W'(1) : w[k];
   endfunction

   assign rot_start = (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
   assign pick_idle = first_req(req, '0);
   assign pick_rot  = first_req(req, rot_start);

   always_comb begin
      busy_d = busy_q;
      idx_d  = idx_q;
      hold_d = hold_q;
      if (!en || req == '0) begin
         busy_d = 1'b0;
      end else if (tick) begin
         if (!busy_q) begin
            busy_d = 1'b1;
            idx_d  = pick_idle;
            hold_d = load_of(weights, pick_idle);
         end else if (hold_q > DATA_W'(1)) begin
            hold_d = hold_q - 1'b1;
         end else begin
            idx_d  = pick_rot;
            hold_d = load_of(weights, pick_rot);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
         hold_q <= '0;
      end else begin
         busy_q <= busy_d;
         idx_q  <= idx_d;
         hold_q <= hold_d;
      end
   end

   for (genvar i = 0; i < N_CLI; i++) begin : g_gnt
      assign grant[i] = busy_q && (idx_q == IDX_W'(i));
   end
endmodule

// File: rtl/wrr_arb_top.sv
module wrr_arb_top
   import wrr_arb_pkg::*;
#(
   parameter int unsigned N_CLI  = 4,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned ADDR_W = $clog2(N_CLI + 3)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arb_en,
   input  logic [N_CLI-1:0]  ext_req,
   input  logic [N_CLI-1:0]  int_req,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [N_CLI-1:0]  grant
);
   initial begin
      assert (N_CLI >= 2) else $error("wrr_arb_top: N_CLI must be at least 2");
      assert (DATA_W >= N_CLI) else $error("wrr_arb_top: DATA_W must hold the mask");
      assert (DATA_W >= 3) else $error("wrr_arb_top: DATA_W must hold the reset period");
   end

   logic [N_CLI-1:0][DATA_W-1:0] weights;
   logic [DATA_W-1:0]            period;
   src_sel_e                     mode;
   logic [N_CLI-1:0]             filt;
   logic [N_CLI-1:0]             req_eff;
   logic                         tick;

   wrr_cfg_regs #(.N_CLI(N_CLI), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .weights(weights), .period(period), .mode(mode), .filt(filt)
   );

   wrr_req_select #(.N_CLI(N_CLI)) u_sel (
      .ext_req(ext_req), .int_req(int_req), .mode(mode), .filt(filt), .req_eff(req_eff)
   );

   wrr_tick_gen #(.DATA_W(DATA_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .en(arb_en), .period(period), .tick(tick)
   );

   wrr_fsm #(.N_CLI(N_CLI), .DATA_W(DATA_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .en(arb_en), .tick(tick), .req(req_eff),
      .weights(weights), .grant(grant)
   );
endmodule

// File: rtl/wrr_arb_chk.sv
module wrr_arb_chk #(
   parameter int unsigned N_CLI = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             arb_en,
   input logic             tick,
   input logic [N_CLI-1:0] req_eff,
   input logic [N_CLI-1:0] grant
);
   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R1

   AST_IDLE_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (!arb_en || req_eff == '0) |=> (grant == '0)); // R6

   AST_STABLE_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && arb_en && req_eff != '0) |=> $stable(grant)); // R9

   AST_IDLE_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && arb_en && grant == '0 && req_eff != '0)
      |=> (grant == $past(req_eff & (~req_eff + 1'b1)))); // R2
endmodule

bind wrr_arb_top wrr_arb_chk #(.N_CLI(N_CLI)) u_chk (
   .clk(clk), .rst_n(rst_n), .arb_en(arb_en), .tick(tick),
   .req_eff(req_eff), .grant(grant)
);

// File: tb/tb_wrr_arb_top.sv
module tb_wrr_arb_top;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       arb_en = 1'b0;
   logic [3:0] ext_req = '0;
   logic [3:0] int_req = '0;
   logic       cfg_we = 1'b0;
   logic [2:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic [3:0] grant;

   int    n_vec = 0;
   int    n_bad = 0;
   string tag = "R1";
   bit    done = 1'b0;

   wrr_arb_top dut (
      .clk(clk), .rst_n(rst_n), .arb_en(arb_en), .ext_req(ext_req), .int_req(int_req),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .grant(grant)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // Requirement model
   int       m_w [4];
   int       m_per, m_cnt, m_idx, m_h;
   bit       m_mode, m_busy;
   bit [3:0] m_filt;

   function automatic int wl(int k);
      return (m_w[k] == 0) ? 1 : m_w[k];
   endfunction

   function automatic int first_from(bit [3:0] r, int s);
      for (int o = 0; o < 4; o++)
         if (r[(s + o) % 4]) return (s + o) % 4;
      return s;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < 4; k++) m_w[k] = 1;
         m_per = 5; m_mode = 0; m_filt = 4'hF;
         m_cnt = 0; m_busy = 0; m_idx = 0; m_h = 0;
      end else begin
         bit [3:0] r;
         bit       tk;
         int       p1, j;
         r  = (m_mode ? int_req : ext_req) & m_filt;
         p1 = (m_per == 0) ? 1 : m_per;
         tk = arb_en && (m_cnt >= p1 - 1);
         m_cnt = (!arb_en || tk) ? 0 : m_cnt + 1;
         if (!arb_en || r == 0) m_busy = 0;
         else if (tk) begin
            if (!m_busy) begin
               j = first_from(r, 0); m_busy = 1; m_idx = j; m_h = wl(j);
            end else if (m_h > 1) m_h = m_h - 1;
            else begin
               j = first_from(r, (m_idx + 1) % 4); m_idx = j; m_h = wl(j);
            end
         end
         if (cfg_we) begin
            case (cfg_addr)
               3'd0, 3'd1, 3'd2, 3'd3: m_w[cfg_addr] = int'(cfg_wdata);
               3'd4: m_per = int'(cfg_wdata);
               3'd5: m_mode = cfg_wdata[0];
               3'd6: m_filt = cfg_wdata[3:0];
               default: ;
            endcase
         end
      end
   end

   function automatic bit [3:0] m_grant();
      return m_busy ? (4'b0001 << m_idx) : 4'b0000;
   endfunction

   always @(negedge clk) begin
      if (!done) begin
         n_vec++;
         if (grant !== m_grant()) begin
            n_bad++;
            $display("FAIL %s: grant=%b expected %b at %0t", tag, grant, m_grant(), $time);
         end
      end
   end

   task automatic chk(string t, bit [3:0] exp);
      n_vec++;
      if (grant !== exp) begin
         n_bad++;
         $display("FAIL %s: grant=%b expected %b", t, grant, exp);
      end
   endtask

   task automatic wr(int a, int d);
      @(negedge clk);
      cfg_we = 1; cfg_addr = 3'(a); cfg_wdata = 8'(d);
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic go_idle();
      @(negedge clk); ext_req = 0; int_req = 0;
      @(negedge clk);
   endtask

   task automatic rnd_run(int n, int chg, bit tog_en, bit tog_cfg);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if ($urandom_range(chg - 1) == 0) begin
            ext_req = 4'($urandom); int_req = 4'($urandom);
         end
         if (tog_en && $urandom_range(15) == 0) arb_en = ~arb_en;
         if (tog_cfg && $urandom_range(63) == 0) begin
            cfg_we = 1;
            cfg_addr = 3'($urandom_range(7));
            cfg_wdata = (cfg_addr == 3'd4) ? 8'($urandom_range(7)) : 8'($urandom_range(4));
            if (cfg_addr == 3'd6 || cfg_addr == 3'd5) cfg_wdata = 8'($urandom);
         end else cfg_we = 0;
      end
      @(negedge clk); cfg_we = 0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_bad++;
      $display("FAIL watchdog: grant=%b expected completion", grant);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      // R1: reset state
      tag = "R1";
      repeat (3) @(negedge clk);
      chk("R1", 4'b0000);
      rst_n = 1;
      // R5 / R8: reset defaults, weight 1 and period 5
      tag = "R5";
      arb_en = 1; ext_req = 4'b0001;
      repeat (4) @(negedge clk);
      chk("R5", 4'b0000);
      @(negedge clk);
      chk("R8", 4'b0001);
      // R4: weights 3 and 1, requests on clients 0..2
      tag = "R4";
      go_idle();
      wr(0, 3); wr(1, 1);
      ext_req = 4'b0111;
      repeat (60) @(negedge clk);
      // R2: all patterns from idle with period 1
      tag = "R2";
      wr(4, 1);
      for (int p = 1; p < 16; p++) begin
         go_idle();
         ext_req = 4'(p);
         @(negedge clk);
         chk("R2", 4'(p) & (~4'(p) + 4'd1));
      end
      // R10: holder drops its own request during hold
      tag = "R10";
      wr(0, 5);
      go_idle();
      ext_req = 4'b0011;
      @(negedge clk);
      chk("R10", 4'b0001);
      ext_req = 4'b0010;
      repeat (2) @(negedge clk);
      chk("R10", 4'b0001);
      repeat (3) @(negedge clk);
      chk("R10", 4'b0010);
      // R3: rotation with unit weights
      tag = "R3";
      for (int k = 0; k < 4; k++) wr(k, 1);
      rnd_run(2000, 4, 0, 0);
      // R7: source select and mask
      tag = "R7";
      wr(5, 1); wr(6, 8'b1011);
      go_idle();
      int_req = 4'b0100; ext_req = 4'b1111;
      repeat (3) @(negedge clk);
      chk("R7", 4'b0000);
      int_req = 4'b0110;
      @(negedge clk);
      chk("R7", 4'b0010);
      rnd_run(2000, 3, 0, 0);
      wr(5, 0); wr(6, 8'hF);
      // R6: enable toggling with period 3
      tag = "R6";
      wr(4, 3);
      rnd_run(3000, 5, 1, 0);
      arb_en = 1;
      // R5: period 0 behaves as 1
      tag = "R5";
      wr(4, 0);
      rnd_run(1000, 6, 0, 0);
      // R9: mixed configuration changes
      tag = "R9";
      rnd_run(8000, 9, 1, 1);
      wr(7, 8'hFF);
      tag = "R8";
      rnd_run(500, 5, 0, 0);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule